// File: doc/BRIEF.md
# Shared-ALU Multi-Cycle Processor Datapath

This block is the datapath half of a 32-bit multi-cycle processor. One ALU does every addition, subtraction and logic operation, and one memory port carries both instruction fetches and data accesses. The work of an instruction is spread over several clock cycles. Between cycles, partial results are held in latched temporaries: the instruction register, the memory data register, the two register-file operand latches and the ALU result latch.

An external sequencer drives every strobe and select on each cycle. The datapath returns the opcode field of the held instruction and an equality flag, and the sequencer uses these to pick its next state. The memory sits outside the block. Read data must be valid on `mem_rdata` within the same cycle that the address is presented. A write is committed at the clock edge by the memory, using the memory's own write enable, which the sequencer drives.

Top module: `mc_datapath`

## Requirements
- R1: While reset is held, and after it is released with no PC strobe, the PC is zero, so `mem_addr` reads 0 when the address select is 0.
- R2: With address select 0, `mem_addr` shows the PC. With address select 1, it shows the ALU result latch.
- R3: The instruction register loads `mem_rdata` only on an edge where the IR-write strobe is high. `opcode` always shows bits 31:26 of the held instruction.
- R4: ALU operand A is the PC when its select is 0 and the A latch when it is 1. Operand B is chosen by a 2-bit select: 00 gives the B latch, 01 gives the constant 4, 10 gives the sign-extended bits 15:0, and 11 gives that value shifted left by 2.
- R5: ALU function select 00 adds and 01 subtracts. Select 10 decodes instruction bits 5:0 as follows: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Any other code adds.
- R6: On every edge, the A latch loads the register named by bits 25:21 and the B latch loads the register named by bits 20:16. `mem_wdata` always shows the B latch.
- R7: On every edge, the ALU result latch loads the current ALU result and the memory data register loads `mem_rdata`.
- R8: When register write is high, a register is written at the edge. The destination is bits 15:11 when the destination select is 1 and bits 20:16 when it is 0. The data is the memory data register when the write-back select is 1 and the ALU result latch when it is 0.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: The PC loads at an edge when the unconditional PC strobe is high, or when the conditional strobe is high and `eq_flag` is 1. The PC source select gives: 00 the live ALU result, 01 the ALU result latch, 10 the jump target.
- R11: The jump target is the top 4 PC bits, then instruction bits 25:0, then two zero bits.
- R12: `eq_flag` is 1 exactly when the live ALU result is zero. With subtract selected on the A and B latches, this means the two registers are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_pc_wr | input | 1 | Unconditional PC load |
| ctl_pc_cond | input | 1 | PC load qualified by `eq_flag` |
| ctl_pc_src | input | 2 | PC source: 00 ALU, 01 ALU latch, 10 jump target |
| ctl_addr_sel | input | 1 | Memory address: 0 PC, 1 ALU latch |
| ctl_ir_wr | input | 1 | Instruction register load |
| ctl_dst_sel | input | 1 | Write destination: 0 bits 20:16, 1 bits 15:11 |
| ctl_wb_sel | input | 1 | Write data: 0 ALU latch, 1 memory data register |
| ctl_rf_wr | input | 1 | Register file write |
| ctl_srca | input | 1 | ALU operand A select |
| ctl_srcb | input | 2 | ALU operand B select |
| ctl_alu_op | input | 2 | ALU function: 00 add, 01 sub, 10 by function field |
| mem_rdata | input | 32 | Read data from memory, valid in the address cycle |
| mem_addr | output | 32 | Byte address to memory |
| mem_wdata | output | 32 | Store data (B latch) |
| opcode | output | 6 | Opcode field of the held instruction |
| eq_flag | output | 1 | ALU result is zero |

## Verification
Most internal state is visible only through the muxes. The PC and the ALU latch appear on `mem_addr`, the B latch on `mem_wdata`, and register contents show up one or two cycles later as operands of a following instruction. A corrupted PC shows at the next fetch as a wrong address. A wrong register write stays hidden until an instruction reads that register, and then it appears as a wrong result on `mem_addr` in that instruction's write-back cycle. For that reason the bench runs a short program in which each written register is read again, including a write to register 0. The final check confirms that a backward branch lands on the address expected from the sign-extended offset.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLT = 3'd4
  } alu_fn_e;

  localparam logic [1:0] AOP_ADD   = 2'b00;
  localparam logic [1:0] AOP_SUB   = 2'b01;
  localparam logic [1:0] AOP_FUNCT = 2'b10;

  localparam logic [5:0] FC_ADD = 6'h20;
  localparam logic [5:0] FC_SUB = 6'h22;
  localparam logic [5:0] FC_AND = 6'h24;
  localparam logic [5:0] FC_OR  = 6'h25;
  localparam logic [5:0] FC_SLT = 6'h2A;

  localparam logic [1:0] SB_REG  = 2'b00;
  localparam logic [1:0] SB_FOUR = 2'b01;
  localparam logic [1:0] SB_IMM  = 2'b10;
  localparam logic [1:0] SB_IMM4 = 2'b11;

  localparam logic [1:0] PS_ALU   = 2'b00;
  localparam logic [1:0] PS_LATCH = 2'b01;
  localparam logic [1:0] PS_JUMP  = 2'b10;
endpackage

// File: rtl/mc_alu_ctl.sv
module mc_alu_ctl
  import mc_dp_pkg::*;
(
  input  logic [1:0] op,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  always_comb begin
    fn = FN_ADD;
    case (op)
      AOP_ADD: fn = FN_ADD;
      AOP_SUB: fn = FN_SUB;
      AOP_FUNCT: begin
        case (funct)
          FC_SUB:  fn = FN_SUB;
          FC_AND:  fn = FN_AND;
          FC_OR:   fn = FN_OR;
          FC_SLT:  fn = FN_SLT;
          default: fn = FN_ADD;
        endcase
      end
      default: fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_dp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res,
  output logic            zero
);
  always_comb begin
    case (fn)
      FN_SUB:  res = opa - opb;
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      FN_SLT:  res = ($signed(opa) < $signed(opb)) ? XLEN'(1) : '0;
      default: res = opa + opb;
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RA_W = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] ra1,
  input  logic [RA_W-1:0] ra2,
  input  logic [RA_W-1:0] wa,
  input  logic [XLEN-1:0] wd,
  input  logic            we,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] rows [NREGS];

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_row
    if (gi == 0) begin : g_zero
      assign rows[gi] = '0;
    end else begin : g_store
      logic [XLEN-1:0] q;
      logic            en;
      assign en = we && (wa == RA_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wd;
      end
      assign rows[gi] = q;
    end
  end

  assign rd1 = rows[ra1];
  assign rd2 = rows[ra2];

  AST_ZERO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0)); // R9

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> (rows[$past(wa)] == $past(wd))); // R8
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RA_W = $clog2(NREGS),
  localparam int IMM_W = 16,
  localparam int OPC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_pc_wr,
  input  logic             ctl_pc_cond,
  input  logic [1:0]       ctl_pc_src,
  input  logic             ctl_addr_sel,
  input  logic             ctl_ir_wr,
  input  logic             ctl_dst_sel,
  input  logic             ctl_wb_sel,
  input  logic             ctl_rf_wr,
  input  logic             ctl_srca,
  input  logic [1:0]       ctl_srcb,
  input  logic [1:0]       ctl_alu_op,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [OPC_W-1:0] opcode,
  output logic             eq_flag
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [XLEN-1:0] pc_q, pc_d, ir_q, ir_d, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] srca, srcb, alu_y, imm_sx, jmp_tgt, pc_next, wb_data;
  logic [XLEN-1:0] rf_rd1, rf_rd2;
  logic [RA_W-1:0] wb_addr;
  logic            alu_zero, pc_en;
  alu_fn_e         alu_fn;

  // operand steering and next-state
  always_comb begin
    imm_sx  = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    jmp_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[XLEN-7:0], 2'b00};
    srca    = ctl_srca ? a_q : pc_q;
    case (ctl_srcb)
      SB_REG:  srcb = b_q;
      SB_FOUR: srcb = XLEN'(4);
      SB_IMM:  srcb = imm_sx;
      default: srcb = imm_sx << 2;
    endcase
    case (ctl_pc_src)
      PS_LATCH: pc_next = aluout_q;
      PS_JUMP:  pc_next = jmp_tgt;
      default:  pc_next = alu_y;
    endcase
    pc_en   = ctl_pc_wr | (ctl_pc_cond & alu_zero);
    pc_d    = pc_en ? pc_next : pc_q;
    ir_d    = ctl_ir_wr ? mem_rdata : ir_q;
    wb_addr = ctl_dst_sel ? ir_q[11 +: RA_W] : ir_q[16 +: RA_W];
    wb_data = ctl_wb_sel ? mdr_q : aluout_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      pc_q     <= pc_d;
      ir_q     <= ir_d;
      mdr_q    <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_y;
    end
  end

  mc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ra1   (ir_q[21 +: RA_W]),
    .ra2   (ir_q[16 +: RA_W]),
    .wa    (wb_addr),
    .wd    (wb_data),
    .we    (ctl_rf_wr),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2)
  );

  mc_alu_ctl u_actl (
    .op    (ctl_alu_op),
    .funct (ir_q[5:0]),
    .fn    (alu_fn)
  );

  mc_alu #(.XLEN(XLEN)) u_alu (
    .fn    (alu_fn),
    .opa   (srca),
    .opb   (srcb),
    .res   (alu_y),
    .zero  (alu_zero)
  );

  assign mem_addr  = ctl_addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[XLEN-1 -: OPC_W];
  assign eq_flag   = alu_zero;

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctl_ir_wr |=> $stable(ir_q)); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctl_pc_wr && !(ctl_pc_cond && eq_flag)) |=> $stable(pc_q)); // R10

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_pc_wr && ctl_pc_src == PS_JUMP) |=>
      (pc_q[1:0] == 2'b00 && pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4]))); // R11

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_rf_wr |=> (mem_wdata == $past(rf_rd2))); // R6
endmodule

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_pc_wr, ctl_pc_cond, ctl_addr_sel, ctl_ir_wr;
  logic        ctl_dst_sel, ctl_wb_sel, ctl_rf_wr, ctl_srca;
  logic [1:0]  ctl_pc_src, ctl_srcb, ctl_alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode;
  logic        eq_flag;
  logic        mem_we;
  logic [31:0] mem [64];

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mc_datapath uut (
    .clk(clk), .rst_n(rst_n),
    .ctl_pc_wr(ctl_pc_wr), .ctl_pc_cond(ctl_pc_cond), .ctl_pc_src(ctl_pc_src),
    .ctl_addr_sel(ctl_addr_sel), .ctl_ir_wr(ctl_ir_wr), .ctl_dst_sel(ctl_dst_sel),
    .ctl_wb_sel(ctl_wb_sel), .ctl_rf_wr(ctl_rf_wr), .ctl_srca(ctl_srca),
    .ctl_srcb(ctl_srcb), .ctl_alu_op(ctl_alu_op), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode), .eq_flag(eq_flag)
  );

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.sel)
        0: act = mem_addr;
        1: act = mem_wdata;
        2: act = {26'b0, opcode};
        3: act = {31'b0, eq_flag};
        default: act = mem[34];
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fc);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fc};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic push(int sel, logic [31:0] e, string tag);
    sbq.push_back('{sel, e, tag});
  endtask

  task automatic idle();
    ctl_pc_wr = 0; ctl_pc_cond = 0; ctl_pc_src = 2'b00; ctl_addr_sel = 0;
    ctl_ir_wr = 0; ctl_dst_sel = 0; ctl_wb_sel = 0; ctl_rf_wr = 0;
    ctl_srca = 0; ctl_srcb = 2'b00; ctl_alu_op = 2'b00; mem_we = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic fetch_dec(logic [31:0] pc, logic [5:0] op, string tag);
    idle(); ctl_ir_wr = 1; ctl_srcb = 2'b01; ctl_pc_wr = 1;
    push(0, pc, tag);
    tick();
    idle(); ctl_srcb = 2'b11;
    push(2, {26'b0, op}, "R3");
    tick();
  endtask

  task automatic do_lw(logic [31:0] addr);
    idle(); ctl_srca = 1; ctl_srcb = 2'b10; tick();
    idle(); ctl_addr_sel = 1;
    push(0, addr, "R7");
    push(2, 32'h23, "R3 hold");
    tick();
    idle(); ctl_wb_sel = 1; ctl_rf_wr = 1; tick();
  endtask

  task automatic do_sw(logic [31:0] addr, logic [31:0] data);
    idle(); ctl_srca = 1; ctl_srcb = 2'b10; tick();
    idle(); ctl_addr_sel = 1; mem_we = 1;
    push(0, addr, "R2");
    push(1, data, "R6");
    tick();
    idle();
    push(4, data, "R6 stored");
  endtask

  task automatic do_r(logic [31:0] res, string tag);
    idle(); ctl_srca = 1; ctl_alu_op = 2'b10; tick();
    idle(); ctl_dst_sel = 1; ctl_rf_wr = 1; ctl_addr_sel = 1;
    push(0, res, tag);
    tick();
  endtask

  task automatic do_beq(logic eq);
    idle(); ctl_srca = 1; ctl_alu_op = 2'b01; ctl_pc_cond = 1; ctl_pc_src = 2'b01;
    push(3, {31'b0, eq}, "R12");
    tick();
  endtask

  task automatic do_j();
    idle(); ctl_pc_wr = 1; ctl_pc_src = 2'b10; tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h23, 0, 1, 16'd128);
    mem[1]  = enc_i(6'h23, 0, 2, 16'd132);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_r(1, 2, 4, 6'h22);
    mem[4]  = enc_r(2, 1, 5, 6'h2A);
    mem[5]  = enc_i(6'h2B, 0, 3, 16'd136);
    mem[6]  = enc_i(6'h04, 1, 2, 16'd3);
    mem[7]  = enc_i(6'h04, 3, 3, 16'd2);
    mem[10] = {6'h02, 26'd12};
    mem[12] = enc_r(1, 2, 0, 6'h20);
    mem[13] = enc_r(0, 0, 6, 6'h20);
    mem[14] = enc_r(1, 2, 7, 6'h25);
    mem[15] = enc_r(1, 2, 8, 6'h24);
    mem[16] = enc_r(4, 5, 9, 6'h20);
    mem[17] = enc_i(6'h04, 0, 0, 16'hFFFF);
    mem[32] = 32'h11;
    mem[33] = 32'h05;

    idle();
    rst_n = 0;
    #7;
    push(0, 32'h0, "R1 in reset");
    tick();
    rst_n = 1;
    tick(); tick(); tick();
    push(0, 32'h0, "R1 after release");
    tick();

    fetch_dec(32'd0,  6'h23, "R2"); do_lw(32'd128);
    fetch_dec(32'd4,  6'h23, "R4"); do_lw(32'd132);
    fetch_dec(32'd8,  6'h00, "R2"); do_r(32'h16, "R5 add");
    fetch_dec(32'd12, 6'h00, "R2"); do_r(32'h0C, "R5 sub");
    fetch_dec(32'd16, 6'h00, "R2"); do_r(32'h01, "R5 slt");
    fetch_dec(32'd20, 6'h2B, "R2"); do_sw(32'd136, 32'h16);
    fetch_dec(32'd24, 6'h04, "R2"); do_beq(1'b0);
    fetch_dec(32'd28, 6'h04, "R10 not taken"); do_beq(1'b1);
    fetch_dec(32'd40, 6'h02, "R10 taken"); do_j();
    fetch_dec(32'd48, 6'h00, "R11 jump"); do_r(32'h16, "R5 add to r0");
    fetch_dec(32'd52, 6'h00, "R2"); do_r(32'h00, "R9 r0 stays zero");
    fetch_dec(32'd56, 6'h00, "R2"); do_r(32'h15, "R5 or");
    fetch_dec(32'd60, 6'h00, "R2"); do_r(32'h01, "R5 and");
    fetch_dec(32'd64, 6'h00, "R2"); do_r(32'h0D, "R8 rd dest");
    fetch_dec(32'd68, 6'h04, "R2"); do_beq(1'b1);
    idle();
    push(0, 32'd68, "R4 negative offset");
    tick();
    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule